// File: doc/BRIEF.md
# Header-Tagged Packet Byte Queue

This block is a synchronous first-in first-out buffer placed on one output port of a packet router. Each stored word is an 8-bit byte plus one marker bit. The marker bit records whether that byte opened a packet. An upstream controller raises a header strobe together with the write enable for the first byte of each packet. The downstream side drains bytes in arrival order, and the marker is returned with each byte so the reader can find packet boundaries.

There are two ways to empty the buffer. The system reset is synchronous and active-low. A separate flush input, active high, lets a supervising circuit discard the stored bytes when the reader stops draining them, and it does this without resetting the rest of the chip. Both take effect at the next rising clock edge.

Top module: `pkt_hdr_fifo`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the block clears itself. Afterwards `empty` is 1, `full` is 0, and `dout` and `dout_first` are both 0.
- R2: A write happens only when `wr_en` is high and `full` is low. After exactly 16 writes with no reads, `full` rises. After 15 writes it is still low.
- R3: A write attempted while `full` is high has no effect. No stored byte is replaced, and `full` stays high.
- R4: A read attempted while `empty` is high has no effect. `dout` and `dout_first` keep their values, and `empty` stays high.
- R5: Bytes leave in the order they were written. A read sampled at a rising edge puts the popped byte on `dout` right after that same edge, and `dout` holds it until the next accepted read.
- R6: The value of `hdr_in` at an accepted write is stored with that byte (1 = first byte of a packet). It appears on `dout_first` in the same cycle that the byte appears on `dout`.
- R7: When read and write are both requested and the buffer is neither empty nor full, the occupancy does not change. The oldest byte is popped and the new byte is appended.
- R8: When read and write are both requested on an empty buffer, only the write happens. On a full buffer, only the read happens, and the offered byte is dropped.
- R9: With `flush` high at a rising edge, all stored bytes are discarded regardless of `wr_en` and `rd_en`. Afterwards `empty` is 1 and `dout`/`dout_first` are 0. The next byte written is the next byte read.
- R10: The storage indices wrap past the last of the 16 entries. Order and markers are preserved across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Synchronous discard of all stored bytes, active high |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| hdr_in | input | 1 | Marks the byte being written as a packet's first byte |
| din | input | 8 | Byte to write |
| full | output | 1 | High when 16 bytes are stored |
| empty | output | 1 | High when no byte is stored |
| dout | output | 8 | Registered byte from the last accepted read |
| dout_first | output | 1 | Marker bit stored with the byte on `dout` |

## Verification
The assertions assume that `rst_n` is held low for at least one rising edge before anything else is checked. They also assume that `flush`, `wr_en` and `rd_en` are stable around each rising edge, because the hold checks compare values across consecutive edges. The bench drives every input on the falling edge and releases the requests before the next falling edge. Each request is therefore sampled at exactly one rising edge and never changes near one. Over-full writes and empty reads are issued on purpose. They are legal inputs that the block must ignore, so no assertion rules them out.

// File: rtl/phf_pkg.sv
package phf_pkg;

    typedef enum logic [1:0] {
        PHF_IDLE = 2'b00,
        PHF_PUSH = 2'b01,
        PHF_POP  = 2'b10,
        PHF_BOTH = 2'b11
    } phf_op_e;

    function automatic phf_op_e phf_classify(input logic push, input logic pop);
        return phf_op_e'({pop, push});
    endfunction

endpackage

// File: rtl/phf_store.sv
module phf_store #(
    parameter int unsigned WORD_W = 9,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] cell_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [WORD_W-1:0] cell_d;
        always_comb begin
            cell_d = cell_q[i];
            if (we && (waddr == PTR_W'(i))) cell_d = wdata;
        end
        always_ff @(posedge clk) cell_q[i] <= cell_d;
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/phf_ctrl.sv
module phf_ctrl #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             push,
    output logic             pop,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             full,
    output logic             empty
);
    import phf_pkg::*;

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t   st_d, st_q;
    phf_op_e op;
    logic    clr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        clr   = !rst_n || flush;
        full  = (st_q.cnt == CNT_W'(DEPTH));
        empty = (st_q.cnt == '0);
        push  = wr_en && !full && !clr;
        pop   = rd_en && !empty && !clr;
        op    = phf_classify(push, pop);
        st_d  = st_q;
        case (op)
            PHF_PUSH: begin
                st_d.wp  = bump(st_q.wp);
                st_d.cnt = st_q.cnt + 1'b1;
            end
            PHF_POP: begin
                st_d.rp  = bump(st_q.rp);
                st_d.cnt = st_q.cnt - 1'b1;
            end
            PHF_BOTH: begin
                st_d.wp = bump(st_q.wp);
                st_d.rp = bump(st_q.rp);
            end
            default: ;
        endcase
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign wr_ptr = st_q.wp;
    assign rd_ptr = st_q.rp;

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    assert_full_empty_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    assert_full_write_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en && !flush) |=> (full && $stable(st_q.wp)));
    assert_both_hold_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && !full && !empty && !flush) |=> $stable(st_q.cnt));
    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && st_q.wp == '0 && st_q.rp == '0));
    assert_ptr_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && st_q.wp == PTR_W'(DEPTH - 1)) |=> (st_q.wp == '0));

endmodule

// File: rtl/phf_outreg.sv
module phf_outreg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              pop,
    input  logic [DATA_W:0]   rword,
    output logic [DATA_W-1:0] dout,
    output logic              dout_first
);

    typedef struct packed {
        logic              first;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (pop) q_d = out_t'(rword);
        if (!rst_n || flush) q_d = '0;
    end

    always_ff @(posedge clk) q_q <= q_d;

    assign dout       = q_q.data;
    assign dout_first = q_q.first;

endmodule

// File: rtl/pkt_hdr_fifo.sv
module pkt_hdr_fifo #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned WORD_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              hdr_in,
    input  logic [DATA_W-1:0] din,
    output logic              full,
    output logic              empty,
    output logic [DATA_W-1:0] dout,
    output logic              dout_first
);

    logic              push, pop;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [WORD_W-1:0] rword;

    phf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .push   (push),
        .pop    (pop),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .full   (full),
        .empty  (empty)
    );

    phf_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (wr_ptr),
        .wdata ({hdr_in, din}),
        .raddr (rd_ptr),
        .rdata (rword)
    );

    phf_outreg #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .pop        (pop),
        .rword      (rword),
        .dout       (dout),
        .dout_first (dout_first)
    );

    assert_empty_read_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en && !flush) |=> (empty && $stable(dout) && $stable(dout_first)));
    assert_flush_zeroes_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (dout == '0 && !dout_first && !full));
    assert_idle_holds_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !flush) |=> $stable(dout));

endmodule

// File: tb/tb_pkt_hdr_fifo.sv
module tb_pkt_hdr_fifo;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, flush = 1'b0, wr_en = 1'b0, rd_en = 1'b0, hdr_in = 1'b0;
    logic [7:0] din = '0;
    logic       full, empty, dout_first;
    logic [7:0] dout;

    int vecs = 0;
    int errs = 0;

    pkt_hdr_fifo dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .rd_en(rd_en),
        .hdr_in(hdr_in), .din(din), .full(full), .empty(empty),
        .dout(dout), .dout_first(dout_first)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic w, input logic r, input logic f, input logic h, input logic [7:0] d);
        wr_en = w; rd_en = r; flush = f; hdr_in = h; din = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; flush = 1'b0; hdr_in = 1'b0; din = '0;
    endtask

    task automatic push(input logic h, input logic [7:0] d);
        tick(1'b1, 1'b0, 1'b0, h, d);
    endtask

    task automatic pop_expect(input string tag, input logic h, input logic [7:0] d);
        tick(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        check({tag, " dout"}, 32'(dout), 32'(d));
        check({tag, " dout_first"}, 32'(dout_first), 32'(h));
    endtask

    task automatic t_reset_R1;
        rst_n = 1'b0;
        tick(0, 0, 0, 0, 0); tick(0, 0, 0, 0, 0);
        rst_n = 1'b1;
        check("R1 empty", 32'(empty), 1); check("R1 full", 32'(full), 0);
        check("R1 dout", 32'(dout), 0);   check("R1 dout_first", 32'(dout_first), 0);
        push(1, 8'h5A); push(0, 8'h6B);
        pop_expect("R1 pre", 1, 8'h5A);
        rst_n = 1'b0;
        tick(0, 0, 0, 0, 0);
        rst_n = 1'b1;
        check("R1 empty after mid reset", 32'(empty), 1);
        check("R1 dout after mid reset", 32'(dout), 0);
        check("R1 first after mid reset", 32'(dout_first), 0);
    endtask

    task automatic t_fill_R2_R3_R5;
        for (int i = 0; i < 15; i++) push(i == 0, 8'(8'h10 + i));
        check("R2 not full at 15", 32'(full), 0);
        check("R2 not empty", 32'(empty), 0);
        push(0, 8'h1F);
        check("R2 full at 16", 32'(full), 1);
        push(1, 8'hEE);
        check("R3 still full", 32'(full), 1);
        for (int i = 0; i < 16; i++) pop_expect("R5 order/R3 intact", i == 0, 8'(8'h10 + i));
        check("R5 empty after drain", 32'(empty), 1);
    endtask

    task automatic t_empty_read_R4;
        tick(0, 1, 0, 0, 0);
        check("R4 dout held", 32'(dout), 32'h1F);
        check("R4 first held", 32'(dout_first), 0);
        check("R4 still empty", 32'(empty), 1);
    endtask

    task automatic t_header_R6;
        push(1, 8'hA1); push(0, 8'h22); push(1, 8'hB3);
        pop_expect("R6 hdr", 1, 8'hA1);
        pop_expect("R6 body", 0, 8'h22);
        pop_expect("R6 hdr2", 1, 8'hB3);
    endtask

    task automatic t_simul_R7_R8;
        push(0, 8'h31); push(0, 8'h32); push(0, 8'h33);
        tick(1, 1, 0, 0, 8'h34);
        check("R7 popped oldest", 32'(dout), 32'h31);
        pop_expect("R7 next", 0, 8'h32);
        pop_expect("R7 next", 0, 8'h33);
        check("R7 one left", 32'(empty), 0);
        pop_expect("R7 appended", 0, 8'h34);
        check("R7 count kept", 32'(empty), 1);
        tick(1, 1, 0, 1, 8'h55);
        check("R8 empty: no read", 32'(dout), 32'h34);
        check("R8 empty: write done", 32'(empty), 0);
        pop_expect("R8 written byte", 1, 8'h55);
        check("R8 drained", 32'(empty), 1);
        for (int i = 0; i < 16; i++) push(0, 8'(8'h60 + i));
        tick(1, 1, 0, 1, 8'hEE);
        check("R8 full: read done", 32'(dout), 32'h60);
        check("R8 full: not full", 32'(full), 0);
        for (int i = 1; i < 16; i++) pop_expect("R8 full: write dropped", 0, 8'(8'h60 + i));
        check("R8 full: empty after 15", 32'(empty), 1);
    endtask

    task automatic t_flush_R9;
        push(0, 8'h71); push(0, 8'h72); push(0, 8'h73);
        pop_expect("R9 pre", 0, 8'h71);
        tick(1, 1, 1, 0, 8'h99);
        check("R9 empty", 32'(empty), 1);
        check("R9 full", 32'(full), 0);
        check("R9 dout zero", 32'(dout), 0);
        push(1, 8'h81);
        pop_expect("R9 fresh byte", 1, 8'h81);
        check("R9 empty again", 32'(empty), 1);
    endtask

    task automatic t_wrap_R10;
        for (int k = 0; k < 4; k++) push(k % 5 == 0, 8'(k));
        for (int k = 4; k < 40; k++) begin
            tick(1, 1, 0, k % 5 == 0, 8'(k));
            check("R10 wrap dout", 32'(dout), 32'(k - 4));
            check("R10 wrap first", 32'(dout_first), 32'((k - 4) % 5 == 0));
        end
        for (int k = 36; k < 40; k++) pop_expect("R10 tail", k % 5 == 0, 8'(k));
        check("R10 empty", 32'(empty), 1);
    endtask

    initial begin
        t_reset_R1();
        t_fill_R2_R3_R5();
        t_empty_read_R4();
        t_header_R6();
        t_simul_R7_R8();
        t_flush_R9();
        t_wrap_R10();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        vecs++; errs++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule